// File: doc/BRIEF.md
# PWM Timer Tick Generator

This block turns one peripheral clock into five count-enable ticks, one per PWM timer channel. Two programmable prescalers divide the peripheral clock. The first prescaler serves timers 0 and 1, and the second serves timers 2, 3 and 4. Each timer then divides its prescaler's tick by a power of two, or switches to an external clock pin shared by its group. All outputs are single-cycle enables in the peripheral clock domain. No clock is derived.

Software programs the block through one write port. Select word 0 holds both prescaler values. Select word 1 holds a packed 4-bit field per timer, and one write to that field sets both the divide ratio and the source. A per-field mask limits a write to the fields it names.

Each timer channel runs a two-state machine:
- `CH_DIV` counts prescaler ticks.
- `CH_EXT` forwards synchronized external edges.
- Transition `SEL_EXT` (into `CH_EXT`) is taken when code 4 is written to the timer's field.
- Transition `SEL_DIV` (into `CH_DIV`) is taken on a write of any other code.

Top module: `tmr_tick_tree`

## Requirements
- R1: Timers 0 and 1 take their prescaled tick from prescaler 0 and their external clock from `ext_clk[0]`. Timers 2, 3 and 4 use prescaler 1 and `ext_clk[1]`.
- R2: In word 0, prescaler 0 sits at bits [7:0] and prescaler 1 at bits [15:8]. A prescaler with field value v emits one tick every v+1 peripheral clocks. A value of 0 is treated as 1, so the ratio is 2.
- R3: Timer i owns bits [4i+3:4i] of word 1. Code 0 divides its prescaler tick by 2, code 1 by 4, code 2 by 8 and code 3 by 16. Codes 5 to 15 divide by 16.
- R4: Code 4 selects the external source. The timer then ticks once per rising edge of its group's pin, after a two-flop synchronizer, and does not tick while the pin is idle.
- R5: A write changes only the fields whose `cfg_mask` bit is set. Bits 0 and 1 of `cfg_mask` select the prescalers in word 0, and bit i selects timer i in word 1. Unselected fields and their tick rates are preserved.
- R6: A prescaler write restarts that prescaler and every divider in its group. If the write is sampled at clock edge E, a timer in divide mode with prescaler ratio P and divide ratio D first ticks at edge E+D*P+1.
- R7: Each tick lasts exactly one clock. In divide mode the spacing between ticks is D*P clocks.
- R8: While `rst_n` is low, all ticks are low. After reset, both prescaler fields and all timer fields are zero, which gives a spacing of 4 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the config port |
| cfg_sel | input | 1 | Word select: 0 for the prescaler word, 1 for the timer field word |
| cfg_mask | input | 5 | Per-field write enables |
| cfg_wdata | input | 20 | Write data |
| ext_clk | input | 2 | External clock pins, one per group, asynchronous |
| tick | output | 5 | Single-cycle count enables, one per timer |

## Verification
The tick spacing is measured on timers with distinct prescaler and divide settings. Each setting yields a different product D*P, so swapped groups, swapped codes or a wrong field position each show up as a wrong spacing. Prescaler values 0 and 255 probe the clamp and the full 8-bit range. A masked write carries garbage in the unselected fields, and the bench then confirms that the neighbouring timers keep their old spacing. The external pins run at two different periods, so a group swap is visible, and stopping one pin must silence only its own group.

// File: rtl/tick_pkg.sv
package tick_pkg;
    typedef enum logic {
        CH_DIV = 1'b0,
        CH_EXT = 1'b1
    } chan_mode_e;

    localparam int DEF_NCH    = 5;
    localparam int DEF_NPSC   = 2;
    localparam int DEF_GRP0_N = 2;
    localparam int DEF_PSC_W  = 8;
    localparam int DEF_FLD_W  = 4;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fld_we,
    input  logic [W-1:0] fld_wdata,
    output logic         pulse
);
    logic [W-1:0] fld_q;
    logic [W-1:0] cnt_q;
    logic [W-1:0] lim;

    // a zero field would mean ratio 1; hold the floor at ratio 2
    always_comb lim = (fld_q == '0) ? W'(1) : fld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      fld_q <= '0;
        else if (fld_we) fld_q <= fld_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pulse <= 1'b0;
        end else if (fld_we) begin
            cnt_q <= '0;
            pulse <= 1'b0;
        end else if (cnt_q == lim) begin
            cnt_q <= '0;
            pulse <= 1'b1;
        end else begin
            cnt_q <= cnt_q + W'(1);
            pulse <= 1'b0;
        end
    end

    a_r2_pulse_gap: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim);
endmodule

// File: rtl/tmr_ext_edge.sv
module tmr_ext_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic edge_o
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= pin;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign edge_o = s2_q & ~s3_q;

    a_r4_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);
endmodule

// File: rtl/tmr_chan_div.sv
module tmr_chan_div
    import tick_pkg::*;
#(
    parameter int FLD_W    = 4,
    parameter int LOG_MAX  = 4,
    parameter int EXT_CODE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fld_we,
    input  logic [FLD_W-1:0] fld_wdata,
    input  logic             grp_restart,
    input  logic             psc_pulse,
    input  logic             ext_edge,
    output logic             tick
);
    localparam int SH_W  = $clog2(LOG_MAX);
    localparam int CNT_W = LOG_MAX;

    chan_mode_e        state_q, state_d;
    logic [SH_W-1:0]   shift_q, shift_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  last;
    logic              restart;

    assign restart = fld_we | grp_restart;

    // next state: SEL_EXT on the external code, SEL_DIV on any other code
    always_comb begin
        state_d = state_q;
        shift_d = shift_q;
        if (fld_we) begin
            if (fld_wdata == FLD_W'(EXT_CODE)) begin
                state_d = CH_EXT;
            end else begin
                state_d = CH_DIV;
                shift_d = (fld_wdata < FLD_W'(LOG_MAX)) ? fld_wdata[SH_W-1:0]
                                                         : SH_W'(LOG_MAX - 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_DIV;
            shift_q <= '0;
        end else begin
            state_q <= state_d;
            shift_q <= shift_d;
        end
    end

    always_comb last = CNT_W'((32'd2 << shift_q) - 32'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (restart) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else begin
            unique case (state_q)
                CH_DIV: begin
                    if (psc_pulse) begin
                        tick  <= (cnt_q == last);
                        cnt_q <= (cnt_q == last) ? '0 : cnt_q + CNT_W'(1);
                    end else begin
                        tick  <= 1'b0;
                    end
                end
                CH_EXT: begin
                    tick  <= ext_edge;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    a_r7_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    a_r3_div_needs_psc: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && $past(state_q == CH_DIV)) |-> $past(psc_pulse));
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last);
endmodule

// File: rtl/tmr_tick_tree.sv
module tmr_tick_tree
    import tick_pkg::*;
#(
    parameter int NCH    = DEF_NCH,
    parameter int NPSC   = DEF_NPSC,
    parameter int GRP0_N = DEF_GRP0_N,
    parameter int PSC_W  = DEF_PSC_W,
    parameter int FLD_W  = DEF_FLD_W,
    localparam int CFG_W = (NCH * FLD_W > NPSC * PSC_W) ? NCH * FLD_W : NPSC * PSC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [NCH-1:0]   cfg_mask,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [NPSC-1:0]  ext_clk,
    output logic [NCH-1:0]   tick
);
    logic [NPSC-1:0] psc_we;
    logic [NPSC-1:0] psc_pulse;
    logic [NPSC-1:0] ext_edge;
    logic [NCH-1:0]  ch_we;

    for (genvar p = 0; p < NPSC; p++) begin : g_psc
        assign psc_we[p] = cfg_we & ~cfg_sel & cfg_mask[p];

        tmr_prescaler #(.W(PSC_W)) u_psc (
            .clk       (clk),
            .rst_n     (rst_n),
            .fld_we    (psc_we[p]),
            .fld_wdata (cfg_wdata[p*PSC_W +: PSC_W]),
            .pulse     (psc_pulse[p])
        );

        tmr_ext_edge u_ext (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin    (ext_clk[p]),
            .edge_o (ext_edge[p])
        );
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int G = (i < GRP0_N) ? 0 : 1;

        assign ch_we[i] = cfg_we & cfg_sel & cfg_mask[i];

        tmr_chan_div #(.FLD_W(FLD_W)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .fld_we      (ch_we[i]),
            .fld_wdata   (cfg_wdata[i*FLD_W +: FLD_W]),
            .grp_restart (psc_we[G]),
            .psc_pulse   (psc_pulse[G]),
            .ext_edge    (ext_edge[G]),
            .tick        (tick[i])
        );
    end

    a_r8_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (tick == '0));
endmodule

// File: tb/tmr_tick_tree_bench.sv
module tmr_tick_tree_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [4:0]  cfg_mask = '0;
    logic [19:0] cfg_wdata = '0;
    logic        ext0 = 1'b0, ext1 = 1'b0;
    logic        ext0_en = 1'b0, ext1_en = 1'b0;
    logic [1:0]  ext_clk;
    logic [4:0]  tick;

    assign ext_clk = {ext1, ext0};

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_tick_tree u_tmr_tick_tree (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_mask  (cfg_mask),
        .cfg_wdata (cfg_wdata),
        .ext_clk   (ext_clk),
        .tick      (tick)
    );

    int checks = 0;
    int errors = 0;

    typedef struct {
        string tag;
        int    val;
    } exp_t;
    exp_t sb_q[$];

    // driver side: queue the expected item
    task automatic expect_val(string tag, int v);
        exp_t e;
        e.tag = tag;
        e.val = v;
        sb_q.push_back(e);
    endtask

    // monitor side: pop and compare against what the design produced
    task automatic monitor_cmp(int actual);
        exp_t e;
        checks++;
        if (sb_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard empty (R7) actual=%0d expected=none", actual);
        end else begin
            e = sb_q.pop_front();
            if (actual != e.val) begin
                errors++;
                $display("FAIL %s actual=%0d expected=%0d", e.tag, actual, e.val);
            end
        end
    endtask

    task automatic wr(input logic sel, input logic [4:0] mask, input logic [19:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_mask = mask; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0; cfg_mask = '0;
    endtask

    task automatic interval(input int ch, output int n);
        do @(negedge clk); while (!tick[ch]);
        n = 0;
        do begin @(negedge clk); n++; end while (!tick[ch]);
    endtask

    task automatic width(input int ch, output int w);
        do @(negedge clk); while (!tick[ch]);
        w = 0;
        while (tick[ch]) begin w++; @(negedge clk); end
    endtask

    task automatic count(input int ch, input int cycles, output int c);
        c = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (tick[ch]) c++;
        end
    endtask

    // external pin generators: ext0 period 10, ext1 period 14
    initial begin
        int c0 = 0;
        forever begin
            @(negedge clk);
            if (ext0_en) begin
                c0++;
                if (c0 == 5) begin ext0 = ~ext0; c0 = 0; end
            end else begin
                ext0 = 1'b0; c0 = 0;
            end
        end
    end

    initial begin
        int c1 = 0;
        forever begin
            @(negedge clk);
            if (ext1_en) begin
                c1++;
                if (c1 == 7) begin ext1 = ~ext1; c1 = 0; end
            end else begin
                ext1 = 1'b0; c1 = 0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (R7) actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        expect_val("R8 ticks low in reset", 0);
        monitor_cmp(int'(tick));
        rst_n = 1'b1;

        // R8 defaults: ratio 2 prescalers, divide by 2
        expect_val("R8 default spacing ch0", 4); interval(0, n); monitor_cmp(n);
        expect_val("R8 default spacing ch4", 4); interval(4, n); monitor_cmp(n);

        // R2 R3: psc0=2 (P=3), psc1=4 (P=5); codes 0,1,2,3,7
        wr(1'b0, 5'b00011, 20'h00402);
        wr(1'b1, 5'b11111, 20'h73210);
        expect_val("R3 ch0 /2 of P0", 6);  interval(0, n); monitor_cmp(n);
        expect_val("R1 ch1 /4 of P0", 12); interval(1, n); monitor_cmp(n);
        expect_val("R1 ch2 /8 of P1", 40); interval(2, n); monitor_cmp(n);
        expect_val("R3 ch3 /16 of P1", 80); interval(3, n); monitor_cmp(n);
        expect_val("R3 ch4 code 7 as /16", 80); interval(4, n); monitor_cmp(n);

        // R2 clamp: field 0 gives ratio 2
        wr(1'b0, 5'b00001, 20'h00000);
        expect_val("R2 zero field ch0", 4); interval(0, n); monitor_cmp(n);
        expect_val("R2 zero field ch1", 8); interval(1, n); monitor_cmp(n);

        // R5: masked write to ch2 only, garbage elsewhere
        wr(1'b1, 5'b00100, 20'hFF0FF);
        // R6: psc1=255 (P=256), restart latency for ch2 (D=2)
        wr(1'b0, 5'b00010, 20'h0FF00);
        n = 1;
        while (!tick[2]) begin @(negedge clk); n++; end
        expect_val("R6 restart latency ch2", 2*256 + 2); monitor_cmp(n);
        expect_val("R7 spacing ch2 P=256 D=2", 512); interval(2, n); monitor_cmp(n);
        expect_val("R5 ch3 field kept", 4096); interval(3, n); monitor_cmp(n);
        expect_val("R5 psc0 kept ch0", 4); interval(0, n); monitor_cmp(n);

        // R4: ch1 and ch4 to external
        wr(1'b1, 5'b10010, 20'h40040);
        ext0_en = 1'b1; ext1_en = 1'b1;
        expect_val("R4 ch1 follows ext0", 10); interval(1, n); monitor_cmp(n);
        expect_val("R4 ch4 follows ext1", 14); interval(4, n); monitor_cmp(n);
        expect_val("R1 ch0 still prescaled", 4); interval(0, n); monitor_cmp(n);
        expect_val("R7 ext tick width", 1); width(4, n); monitor_cmp(n);
        expect_val("R7 div tick width", 1); width(0, n); monitor_cmp(n);

        ext0_en = 1'b0;
        repeat (20) @(negedge clk);
        expect_val("R4 idle ext0 silent ch1", 0); count(1, 60, n); monitor_cmp(n);
        expect_val("R4 ext1 group unaffected", 5); count(4, 70, n); monitor_cmp(n);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule